// File: doc/BRIEF.md
# Field-Synchronous Track Jump Sequencer

This block drives the jump request line and the scan direction line of a video disc player. Together these two lines set the playback speed and direction. A slow periodic tick comes from bit 5 of the video line counter, so a rising edge arrives once every 64 lines. Each tick advances a frame phase counter that runs from 1 to 8. Phase 1 opens a new frame. Phase 8 is the time-critical slot just before the frame ends, and it is the only place where jump pulses are sent.

The counter is pulled back to phase 1 when vertical sync ends after a bottom field. The field flag must already be valid when the sync pulse falls. A 3-bit mode code selects how many jumps go out in the phase-8 slot and which way the head moves. The code is captured only at the moment the phase becomes 1, so a change of code never splits a burst.

Pulse and gap widths are given in microseconds and converted to clock cycles from a clock-frequency parameter. Each jump is an active-low pulse, and the player acts on its falling edge.

Top module: `jump_sequencer`

## Requirements
- R1: After reset, `jump_n` is 1, `dir_fwd` is 0 and `phase` is 1. The captured mode is still-frame, whatever the value on `mode`.
- R2: Each rising edge of `line_bit5` advances `phase` by one on the clock edge that samples the new high level. After 8 the phase wraps to 1. Holding `line_bit5` high gives no further advance.
- R3: When `vsync` falls while `field_bottom` is 1, `phase` becomes 1 on that clock edge. This resync takes priority over a tick. When `vsync` falls while `field_bottom` is 0, the phase does not change.
- R4: `mode` is captured only on the edge where `phase` becomes 1, by wrap or by resync. A change of `mode` at any other time has no effect on the next burst or on `dir_fwd`.
- R5: Jump count per code: 0 still-frame gives 1; 1 gives 0 (1x forward); 2 gives 1 (2x forward); 3 gives 2 (3x forward); 4 gives 3 (4x forward); 5 gives 2 (1x reverse); 6 gives 3 (2x reverse); 7 is reserved and acts as still-frame (1).
- R6: Each pulse holds `jump_n` low for exactly PULSE_US × CLK_HZ / 10^6 clock cycles.
- R7: Inside one burst, consecutive pulses are separated by a high gap of exactly max(GAP_US, PULSE_US) × CLK_HZ / 10^6 cycles.
- R8: A burst starts, with `jump_n` going low, on the clock edge where `phase` goes from 7 to 8. No pulse starts at any other phase step.
- R9: `dir_fwd` is 1 for codes 1 to 4 and 0 for codes 0, 5, 6 and 7. It follows the captured mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_bit5 | input | 1 | Bit 5 of the vertical line counter; its rising edge is the phase tick |
| vsync | input | 1 | Vertical sync, active high; its falling edge is the resync point |
| field_bottom | input | 1 | High when the field that just ended is the bottom field |
| mode | input | 3 | Playback mode code (see R5) |
| jump_n | output | 1 | Active-low track jump pulse |
| dir_fwd | output | 1 | Scan direction: 1 forward, 0 reverse or pause |
| phase | output | 4 | Current frame phase, 1 to 8 |

## Verification
Phase, direction and the start of a burst all change on the clock edge that first samples the stimulus. Inputs change at a falling clock edge, so every result is read at the next falling edge. The bench measures each burst by counting falling-edge samples: low runs against the pulse width, high runs between pulses against the gap, and transitions against the expected jump count. It keeps watching for a full gap after the last pulse, so any extra pulse would be seen. Mode capture is tested by changing `mode` in the middle of a frame and confirming that `dir_fwd` and the next burst still follow the old code.

// File: rtl/jseq_pkg.sv
package jseq_pkg;

  typedef enum logic [2:0] {
    M_STILL = 3'd0,
    M_FWD1  = 3'd1,
    M_FWD2  = 3'd2,
    M_FWD3  = 3'd3,
    M_FWD4  = 3'd4,
    M_REV1  = 3'd5,
    M_REV2  = 3'd6,
    M_RSVD  = 3'd7
  } play_mode_e;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_LOW  = 2'd1,
    PS_GAP  = 2'd2
  } pulse_st_e;

  function automatic logic [1:0] jumps_of(play_mode_e m);
    case (m)
      M_FWD1:  return 2'd0;
      M_FWD2:  return 2'd1;
      M_FWD3:  return 2'd2;
      M_FWD4:  return 2'd3;
      M_REV1:  return 2'd2;
      M_REV2:  return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic fwd_of(play_mode_e m);
    return (m == M_FWD1) || (m == M_FWD2) || (m == M_FWD3) || (m == M_FWD4);
  endfunction

endpackage

// File: rtl/jseq_edges.sv
module jseq_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic line_bit5,
  input  logic vsync,
  input  logic field_bottom,
  output logic tick,
  output logic resync
);
  logic lb_q;
  logic vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_q <= 1'b1;
      vs_q <= 1'b0;
    end else begin
      lb_q <= line_bit5;
      vs_q <= vsync;
    end
  end

  assign tick   = line_bit5 & ~lb_q;
  assign resync = vs_q & ~vsync & field_bottom;

endmodule

// File: rtl/jseq_phase.sv
module jseq_phase
  import jseq_pkg::*;
#(
  parameter int PHASES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       resync,
  input  logic [2:0] mode_in,
  output logic [3:0] phase,
  output play_mode_e mode_q,
  output logic       go
);
  localparam logic [3:0] LAST = 4'(PHASES);
  localparam logic [3:0] PRE  = 4'(PHASES - 1);

  logic       wrap;
  logic       enter_one;

  assign wrap      = tick && (phase == LAST);
  assign enter_one = resync || wrap;
  assign go        = tick && !resync && (phase == PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= 4'd1;
      mode_q <= M_STILL;
    end else begin
      if (enter_one) begin
        phase  <= 4'd1;
        mode_q <= play_mode_e'(mode_in);
      end else if (tick) begin
        phase  <= phase + 4'd1;
      end
    end
  end

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase >= 4'd1) && (phase <= LAST));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !resync) |=>
      (phase == (($past(phase) == LAST) ? 4'd1 : $past(phase) + 4'd1)));

endmodule

// File: rtl/jseq_pulse.sv
module jseq_pulse
  import jseq_pkg::*;
#(
  parameter int LOW_CYC = 96,
  parameter int GAP_CYC = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [1:0] njumps,
  output logic       jump_n
);
  localparam int MAXC = (LOW_CYC > GAP_CYC) ? LOW_CYC : GAP_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int RW   = $clog2(LOW_CYC + 2);

  pulse_st_e       st;
  logic [TW-1:0]   tmr;
  logic [1:0]      rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PS_IDLE;
      tmr    <= '0;
      rem    <= '0;
      jump_n <= 1'b1;
    end else begin
      case (st)
        PS_IDLE: begin
          if (go && (njumps != 2'd0)) begin
            st     <= PS_LOW;
            tmr    <= TW'(LOW_CYC - 1);
            rem    <= njumps;
            jump_n <= 1'b0;
          end
        end
        PS_LOW: begin
          if (tmr == '0) begin
            jump_n <= 1'b1;
            rem    <= rem - 2'd1;
            if (rem > 2'd1) begin
              st  <= PS_GAP;
              tmr <= TW'(GAP_CYC - 1);
            end else begin
              st  <= PS_IDLE;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        PS_GAP: begin
          if (tmr == '0) begin
            st     <= PS_LOW;
            tmr    <= TW'(LOW_CYC - 1);
            jump_n <= 1'b0;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: begin
          st     <= PS_IDLE;
          jump_n <= 1'b1;
        end
      endcase
    end
  end

  logic [RW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_run <= '0;
    else if (!jump_n) low_run <= low_run + 1'b1;
    else             low_run <= '0;
  end

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jump_n) |-> (low_run == RW'(LOW_CYC)));

endmodule

// File: rtl/jump_sequencer.sv
module jump_sequencer
  import jseq_pkg::*;
#(
  parameter int CLK_HZ   = 1_000_000,
  parameter int PULSE_US = 96,
  parameter int GAP_US   = 96,
  parameter int PHASES   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_bit5,
  input  logic       vsync,
  input  logic       field_bottom,
  input  logic [2:0] mode,
  output logic       jump_n,
  output logic       dir_fwd,
  output logic [3:0] phase
);
  localparam int KHZ     = CLK_HZ / 1000;
  localparam int LOW_CYC = (KHZ * PULSE_US) / 1000;
  localparam int GAP_RAW = (KHZ * GAP_US) / 1000;
  localparam int GAP_CYC = (GAP_RAW > LOW_CYC) ? GAP_RAW : LOW_CYC;

  logic       tick;
  logic       resync;
  logic       go;
  play_mode_e mode_q;
  logic [1:0] njumps;

  jseq_edges u_edges (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_bit5    (line_bit5),
    .vsync        (vsync),
    .field_bottom (field_bottom),
    .tick         (tick),
    .resync       (resync)
  );

  jseq_phase #(.PHASES(PHASES)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .resync  (resync),
    .mode_in (mode),
    .phase   (phase),
    .mode_q  (mode_q),
    .go      (go)
  );

  assign njumps  = jumps_of(mode_q);
  assign dir_fwd = fwd_of(mode_q);

  jseq_pulse #(.LOW_CYC(LOW_CYC), .GAP_CYC(GAP_CYC)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .njumps (njumps),
    .jump_n (jump_n)
  );

  // R3
  resync_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (phase == 4'd1));

  // R8
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (njumps != 2'd0) && jump_n) |=> !jump_n);

  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_fwd) |-> (phase == 4'd1));

endmodule

// File: tb/jump_sequencer_test.sv
module jump_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int P = 96;
  localparam int G = 150;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_bit5 = 1'b0;
  logic       vsync = 1'b0;
  logic       field_bottom = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       jump_n;
  logic       dir_fwd;
  logic [3:0] phase;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jump_sequencer #(.CLK_HZ(1_000_000), .PULSE_US(96), .GAP_US(150), .PHASES(8)) uut (
    .clk(clk), .rst_n(rst_n), .line_bit5(line_bit5), .vsync(vsync),
    .field_bottom(field_bottom), .mode(mode), .jump_n(jump_n),
    .dir_fwd(dir_fwd), .phase(phase)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) line_bit5 = 1'b1;
    @(negedge clk) line_bit5 = 1'b0;
  endtask

  task automatic do_vsync(bit bottom);
    @(negedge clk) begin vsync = 1'b1; field_bottom = bottom; end
    @(negedge clk);
    @(negedge clk) vsync = 1'b0;
    @(negedge clk) field_bottom = 1'b0;
  endtask

  task automatic measure(int expn, string req);
    int lowlen = 0;
    int hilen = 0;
    int pulses = 0;
    bit prev = 1'b1;
    int limit = expn * (P + G) + G + 40;
    for (int i = 0; i < limit; i++) begin
      if (jump_n == 1'b0) begin
        if (prev && pulses > 0) chk(hilen == G, "R7", hilen, G);
        lowlen++;
        hilen = 0;
      end else begin
        if (!prev) begin
          chk(lowlen == P, "R6", lowlen, P);
          pulses++;
          lowlen = 0;
        end
        hilen++;
      end
      prev = jump_n;
      @(negedge clk);
    end
    chk(pulses == expn, req, pulses, expn);
  endtask

  task automatic to_phase7_quiet();
    int lows = 0;
    while (phase != 4'd7) begin
      do_tick();
      if (jump_n == 1'b0) lows++;
    end
    chk(lows == 0, "R8 no pulse before phase 8", lows, 0);
  endtask

  task automatic t_reset();
    chk(jump_n == 1'b1, "R1 jump_n", jump_n, 1);
    chk(dir_fwd == 1'b0, "R1 dir", dir_fwd, 0);
    chk(phase == 4'd1, "R1 phase", phase, 1);
  endtask

  task automatic t_first_frame();
    for (int k = 2; k <= 7; k++) begin
      do_tick();
      chk(phase == 4'(k), "R2 advance", phase, k);
    end
    chk(jump_n == 1'b1, "R8 quiet", jump_n, 1);
    do_tick();
    chk(phase == 4'd8, "R2 to 8", phase, 8);
    chk(jump_n == 1'b0, "R8 start edge", jump_n, 0);
    measure(1, "R5 still after reset");
    chk(dir_fwd == 1'b0, "R4 dir before capture", dir_fwd, 0);
  endtask

  task automatic t_wrap_and_hold();
    @(negedge clk) line_bit5 = 1'b1;
    @(negedge clk);
    chk(phase == 4'd1, "R2 wrap", phase, 1);
    chk(dir_fwd == 1'b1, "R9 fwd2 dir", dir_fwd, 1);
    repeat (5) @(negedge clk);
    chk(phase == 4'd1, "R2 held high", phase, 1);
    line_bit5 = 1'b0;
    @(negedge clk) mode = 3'd6;
    @(negedge clk);
    chk(dir_fwd == 1'b1, "R4 mid-frame change", dir_fwd, 1);
    to_phase7_quiet();
    do_tick();
    measure(1, "R4 old mode burst");
  endtask

  task automatic t_resync();
    do_vsync(1'b0);
    chk(phase == 4'd8, "R3 top field ignored", phase, 8);
    do_vsync(1'b1);
    chk(phase == 4'd1, "R3 resync", phase, 1);
    chk(dir_fwd == 1'b0, "R9 rev2 dir", dir_fwd, 0);
  endtask

  task automatic t_frame(logic [2:0] m, int expn, bit expdir);
    mode = m;
    do_vsync(1'b1);
    chk(phase == 4'd1, "R3 resync", phase, 1);
    chk(dir_fwd == expdir, "R9 dir", dir_fwd, expdir);
    to_phase7_quiet();
    do_tick();
    measure(expn, "R5 jump count");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mode = 3'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_frame();
    t_wrap_and_hold();
    t_resync();
    to_phase7_quiet();
    do_tick();
    measure(3, "R5 rev2");
    t_frame(3'd1, 0, 1'b1);
    t_frame(3'd3, 2, 1'b1);
    t_frame(3'd4, 3, 1'b1);
    t_frame(3'd5, 2, 1'b0);
    t_frame(3'd7, 1, 1'b0);
    t_frame(3'd0, 1, 1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule